// File: doc/BRIEF.md
# Audio Receiver Status Flag Collector

This block sits beside the line decoder of a biphase-mark audio receiver. It turns single-cycle event pulses from the decoder into sticky status flags and one interrupt request. The events are:

- a control word becoming available
- a subframe parity failure
- a block-start preamble
- completion of the initial lock
- a framing violation
- a lock failure after all retries
- a timeout between line transitions

Software or a host sequencer sees the flags on one status vector. The flags clear in one of three ways:

- Control-ready clears when the control word is read.
- Parity, block-start and lock-done clear when a 1 is written to their bit in a clear strobe vector.
- The three receive errors clear only while the receiver enable is low.

A framing violation is only recorded once the lock-done flag is already set, so noise during acquisition is not reported. Each flag has an interrupt enable, except that the three receive errors share one. The request output is the registered OR of all flags that are both set and enabled. Reset is asserted asynchronously and released through a short synchronizer.

Top module: `rxsf_status_flags`

## Requirements
- R1: Status bit 0 (control-ready) sets the cycle after `ctrl_evt_i` and clears the cycle after `ctrl_rd_i`.
- R2: Status bit 1 (parity error) sets the cycle after `par_err_evt_i` and then stays set until it is cleared.
- R3: Status bit 2 (block start) sets on `blk_start_evt_i`, and status bit 3 (lock done) sets on `sync_done_evt_i`. Both update the cycle after the event.
- R4: `w1c_i` bit 0 clears status bit 1, bit 1 clears status bit 2, and bit 2 clears status bit 3. A zero bit has no effect. Without a clear, these flags hold their value.
- R5: Status bit 4 (framing error) sets on `frame_err_evt_i` only when status bit 3 is already 1 in that cycle. At any other time the event is ignored.
- R6: Status bit 5 (lock failure) sets on `sync_fail_evt_i`, and status bit 6 (timeout) sets on `timeout_evt_i`. Both set only while `rx_en_i` is 1.
- R7: With `rx_en_i` at 0, status bits 4 to 6 are 0 from the next cycle on. `ctrl_rd_i` and `w1c_i` never change these bits.
- R8: When a set event and its read or write-one clear occur in the same cycle, the flag ends up set.
- R9: `irq_en_i` bits 0 to 3 enable status bits 0 to 3 one to one. `irq_en_i` bit 4 enables status bits 4 to 6 together. `irq_o` is the OR of the enabled set flags, registered, so it follows the flags by one cycle.
- R10: While `rst_ni` is low, all flags and `irq_o` are 0 at once. After `rst_ni` rises, the internal reset is released on the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receiver enable; low clears the error flags |
| ctrl_evt_i | input | 1 | Control word ready pulse |
| par_err_evt_i | input | 1 | Parity failure pulse |
| blk_start_evt_i | input | 1 | Block-start preamble pulse |
| sync_done_evt_i | input | 1 | Lock completed pulse |
| frame_err_evt_i | input | 1 | Framing violation pulse |
| sync_fail_evt_i | input | 1 | Lock failure pulse |
| timeout_evt_i | input | 1 | Transition timeout pulse |
| ctrl_rd_i | input | 1 | Control word read strobe |
| w1c_i | input | 3 | Write-one-to-clear strobes |
| irq_en_i | input | 5 | Interrupt enables |
| status_o | output | 7 | Sticky status flags |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check several properties on every cycle:

- A framing flag can only rise after the lock-done flag was set.
- A disabled receiver holds the error flags at zero.
- Reads and write-one strobes clear only their own flags, when no set event arrives in the same cycle.
- The request output equals the previous cycle's masked OR.

The bench scenarios cover the rest. They show that a gated framing event leaves no trace once lock is reached later, and that a set beats a clear in the same cycle. They also show the shared error enable and the reset release latency.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  localparam int unsigned NUM_FLAGS = 7;
  localparam int unsigned W1C_W     = 3;
  localparam int unsigned IE_W      = 5;

  localparam int unsigned F_CTRL    = 0;
  localparam int unsigned F_PAR     = 1;
  localparam int unsigned F_BLK     = 2;
  localparam int unsigned F_SYNC    = 3;
  localparam int unsigned F_FRAME   = 4;
  localparam int unsigned F_SFAIL   = 5;
  localparam int unsigned F_TMO     = 6;

  localparam int unsigned W1C_BASE  = F_PAR;
  localparam int unsigned ERR_BASE  = F_FRAME;
  localparam int unsigned ERR_N     = NUM_FLAGS - ERR_BASE;
  localparam int unsigned IE_ERR    = IE_W - 1;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rxsf_rst_sync.sv
module rxsf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_sync_no = pipe_q[STAGES-1];
endmodule

// File: rtl/rxsf_flag_cell.sv
module rxsf_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic upd;

  always_comb begin
    upd = set_i | clr_i | kill_i;
    if (kill_i)      flag_d = 1'b0;
    else if (set_i)  flag_d = 1'b1;
    else if (clr_i)  flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rxsf_irq_gen.sv
module rxsf_irq_gen
  import rxsf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  flag_vec_t       flags_i,
  input  logic [IE_W-1:0] en_i,
  output logic            irq_o
);
  logic [NUM_FLAGS-1:0] en_exp;
  logic                 req_d;
  logic                 req_q;

  always_comb begin
    for (int i = 0; i < NUM_FLAGS; i++) begin
      if (i < ERR_BASE) en_exp[i] = en_i[i];
      else              en_exp[i] = en_i[IE_ERR];
    end
    req_d = |(flags_i & en_exp);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign irq_o = req_q;
endmodule

// File: rtl/rxsf_status_flags.sv
module rxsf_status_flags
  import rxsf_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_en_i,
  input  logic                 ctrl_evt_i,
  input  logic                 par_err_evt_i,
  input  logic                 blk_start_evt_i,
  input  logic                 sync_done_evt_i,
  input  logic                 frame_err_evt_i,
  input  logic                 sync_fail_evt_i,
  input  logic                 timeout_evt_i,
  input  logic                 ctrl_rd_i,
  input  logic [W1C_W-1:0]     w1c_i,
  input  logic [IE_W-1:0]      irq_en_i,
  output logic [NUM_FLAGS-1:0] status_o,
  output logic                 irq_o
);
  logic      rst_int_n;
  flag_vec_t set_v;
  flag_vec_t clr_v;
  flag_vec_t kill_v;
  flag_vec_t flags;

  rxsf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  always_comb begin
    set_v          = '0;
    set_v[F_CTRL]  = ctrl_evt_i;
    set_v[F_PAR]   = par_err_evt_i;
    set_v[F_BLK]   = blk_start_evt_i;
    set_v[F_SYNC]  = sync_done_evt_i;
    set_v[F_FRAME] = frame_err_evt_i & flags[F_SYNC];
    set_v[F_SFAIL] = sync_fail_evt_i;
    set_v[F_TMO]   = timeout_evt_i;
  end

  always_comb begin
    clr_v         = '0;
    clr_v[F_CTRL] = ctrl_rd_i;
    for (int i = 0; i < W1C_W; i++) clr_v[W1C_BASE+i] = w1c_i[i];
  end

  always_comb begin
    kill_v = '0;
    for (int i = 0; i < ERR_N; i++) kill_v[ERR_BASE+i] = ~rx_en_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rxsf_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .kill_i (kill_v[g]),
      .flag_o (flags[g])
    );
  end

  rxsf_irq_gen u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .flags_i (flags),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );

  assign status_o = flags;
endmodule

// File: rtl/rxsf_status_sva.sv
module rxsf_status_sva
  import rxsf_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_en_i,
  input logic                 ctrl_evt_i,
  input logic                 par_err_evt_i,
  input logic                 blk_start_evt_i,
  input logic                 ctrl_rd_i,
  input logic [W1C_W-1:0]     w1c_i,
  input logic [IE_W-1:0]      irq_en_i,
  input logic [NUM_FLAGS-1:0] status_o,
  input logic                 irq_o
);
  AST_CTRL_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_i && !ctrl_evt_i) |=> !status_o[F_CTRL]); // R1
  AST_PAR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[F_PAR] && !w1c_i[0]) |=> status_o[F_PAR]); // R2
  AST_BLK_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_i[1] && !blk_start_evt_i) |=> !status_o[F_BLK]); // R4
  AST_FRAME_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[F_FRAME]) |-> $past(status_o[F_SYNC])); // R5
  AST_SFAIL_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[F_SFAIL]) |-> $past(rx_en_i)); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (status_o[NUM_FLAGS-1:ERR_BASE] == '0)); // R7
  AST_PAR_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_evt_i |=> status_o[F_PAR]); // R8
  AST_IRQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past((|(status_o[ERR_BASE-1:0] & irq_en_i[ERR_BASE-1:0])) |
                   ((|status_o[NUM_FLAGS-1:ERR_BASE]) & irq_en_i[IE_ERR]))); // R9
endmodule

bind rxsf_status_flags rxsf_status_sva u_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rx_en_i         (rx_en_i),
  .ctrl_evt_i      (ctrl_evt_i),
  .par_err_evt_i   (par_err_evt_i),
  .blk_start_evt_i (blk_start_evt_i),
  .ctrl_rd_i       (ctrl_rd_i),
  .w1c_i           (w1c_i),
  .irq_en_i        (irq_en_i),
  .status_o        (status_o),
  .irq_o           (irq_o)
);

// File: tb/rxsf_status_flags_tb.sv
module rxsf_status_flags_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 17;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en;
  logic [6:0] ev;
  logic       rd;
  logic [2:0] w1c;
  logic [4:0] ie;
  logic [6:0] status;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  // vector: ev[6:0] (tmo,sfail,frame,sync,blk,par,ctrl), rd, w1c[2:0], en, expected status
  localparam logic [18:0] VEC [NV] = '{
    {7'b0000000, 1'b0, 3'b000, 1'b1, 7'b0000000},
    {7'b0010000, 1'b0, 3'b000, 1'b1, 7'b0000000}, // R5 frame ignored before lock
    {7'b0000001, 1'b0, 3'b000, 1'b1, 7'b0000001}, // R1
    {7'b0001000, 1'b0, 3'b000, 1'b1, 7'b0001001}, // R3
    {7'b0010000, 1'b0, 3'b000, 1'b1, 7'b0011001}, // R5
    {7'b0000110, 1'b0, 3'b000, 1'b1, 7'b0011111}, // R2 R3
    {7'b0000000, 1'b1, 3'b000, 1'b1, 7'b0011110}, // R1
    {7'b0000000, 1'b0, 3'b001, 1'b1, 7'b0011100}, // R4
    {7'b0000100, 1'b0, 3'b010, 1'b1, 7'b0011100}, // R8
    {7'b0000000, 1'b1, 3'b100, 1'b1, 7'b0010100}, // R4 R7
    {7'b1100000, 1'b0, 3'b000, 1'b1, 7'b1110100}, // R6
    {7'b0010000, 1'b0, 3'b000, 1'b1, 7'b1110100}, // R5
    {7'b0000000, 1'b0, 3'b000, 1'b0, 7'b0000100}, // R7
    {7'b1100000, 1'b0, 3'b000, 1'b0, 7'b0000100}, // R6 R7
    {7'b0000000, 1'b0, 3'b010, 1'b1, 7'b0000000}, // R4
    {7'b0011000, 1'b0, 3'b000, 1'b1, 7'b0001000}, // R5
    {7'b0000001, 1'b1, 3'b000, 1'b1, 7'b0001001}  // R8
  };

  rxsf_status_flags u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .rx_en_i         (rx_en),
    .ctrl_evt_i      (ev[0]),
    .par_err_evt_i   (ev[1]),
    .blk_start_evt_i (ev[2]),
    .sync_done_evt_i (ev[3]),
    .frame_err_evt_i (ev[4]),
    .sync_fail_evt_i (ev[5]),
    .timeout_evt_i   (ev[6]),
    .ctrl_rd_i       (rd),
    .w1c_i           (w1c),
    .irq_en_i        (ie),
    .status_o        (status),
    .irq_o           (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ev = '0; rd = 1'b0; w1c = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; ev = '0; rd = 1'b0; w1c = '0; ie = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset status", {1'b0, status}, 8'h00);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    // R10: an event on the first edge after release is still swallowed by the synchronizer
    ev = 7'b0000001;
    step();
    chk("R10 release latency", {1'b0, status}, 8'h00);
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ev    = VEC[i][18:12];
      rd    = VEC[i][11];
      w1c   = VEC[i][10:8];
      rx_en = VEC[i][7];
      step();
      chk($sformatf("vector %0d", i), {1'b0, status}, {1'b0, VEC[i][6:0]});
    end

    // R9 control enable, one-cycle lag
    ie = 5'b00001;
    step();
    chk("R9 irq ctrl enabled", {7'b0, irq}, 8'h01);
    rd = 1'b1;
    step();
    chk("R1 ctrl cleared", {7'b0, status[0]}, 8'h00);
    chk("R9 irq lags flag", {7'b0, irq}, 8'h01);
    step();
    chk("R9 irq drops", {7'b0, irq}, 8'h00);
    // R9 shared error enable
    ie = 5'b10000;
    ev = 7'b1000000;
    step();
    chk("R6 timeout set", {7'b0, status[6]}, 8'h01);
    chk("R9 irq not yet", {7'b0, irq}, 8'h00);
    step();
    chk("R9 irq shared err", {7'b0, irq}, 8'h01);
    ie = 5'b01111;
    step();
    step();
    chk("R9 err masked", {7'b0, irq}, 8'h01); // lock-done still set and enabled
    w1c = 3'b100;
    step();
    step();
    chk("R9 all masked", {7'b0, irq}, 8'h00);

    // R10 asynchronous assertion mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async clear", {1'b0, status}, 8'h00);
    chk("R10 async irq", {7'b0, irq}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule